// File: doc/BRIEF.md
# Refresh Row Scheduler

This block decides when a dynamic memory row must be refreshed and which row is next. Charge stored in each cell leaks away steadily, so every row has to be refreshed at least once in every retention window (64 ms by default). The scheduler holds a prescaled timer and a row counter. It hands one row address at a time to a memory controller over a valid/ready handshake. The controller issues the actual refresh command. The retention period, the number of rows and the clock period are parameters, and the timer limits are computed from them at elaboration.

There are two modes, selected by a plain level input. In spread mode, one row is requested every `INTERVAL = floor(RETENTION_NS / ROWS / CLK_PERIOD_NS)` cycles. With the defaults (4096 rows, 64 ms, 20 ns clock) that is 781 cycles, about 15.6 µs. In burst mode, the timer runs for the whole window, `WINDOW = floor(RETENTION_NS / CLK_PERIOD_NS)` cycles, and then requests every row back to back. Both modes do the same total refresh work per window. The row counter advances only on an accepted handshake and wraps from the last row to row 0.

Back-pressure rules: the controller may hold `refresh_ready` low for as long as it needs. While it does, `refresh_valid` stays high and `refresh_row` stays unchanged. Spread-mode intervals that expire during a stall are counted as owed refreshes, up to 8, and are served back to back once ready returns. A handshake takes place at a rising clock edge where both valid and ready are high.

Top module: `refresh_scheduler`

## Requirements
- R1: A synchronous active-high `rst` clears the timer, the row counter, the owed count and any burst in progress. After reset, `refresh_valid` = 0, `refresh_row` = 0 and `burst_active` = 0, and timing restarts from the first edge after release.
- R2: In spread mode (`mode_burst` = 0), `refresh_valid` first rises after the INTERVAL-th rising edge following reset release. With `refresh_ready` held high, consecutive handshakes are exactly INTERVAL cycles apart.
- R3: Once `refresh_valid` is high, it stays high and `refresh_row` holds its value until a handshake (`refresh_valid` && `refresh_ready` at a rising edge).
- R4: `refresh_row` increases by one after each handshake and changes at no other time.
- R5: After a handshake on row ROWS-1, `refresh_row` becomes 0.
- R6: In spread mode, each expired interval adds one owed refresh, and the owed count saturates at 8. After a stall spanning more than 8 intervals, exactly 8 back-to-back handshakes are offered before `refresh_valid` drops.
- R7: In burst mode (`mode_burst` = 1), `refresh_valid` first rises after the WINDOW-th rising edge following reset release. It then stays high, through any stalls, until ROWS handshakes have completed. If the window expires again while a burst is still running, the burst restarts with a full row count.
- R8: `burst_active` is 1 from the edge of the first handshake of a burst up to the edge of its last handshake, and is 0 after that last handshake.
- R9: A change of `mode_burst` restarts the timer at the first edge that sees the new value. The first request of the new mode appears one full new-mode period after that edge. Refreshes already owed are still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_burst | input | 1 | 0 = spread mode, 1 = burst mode |
| refresh_valid | output | 1 | A row refresh is requested |
| refresh_ready | input | 1 | Controller accepts the requested row |
| refresh_row | output | $clog2(ROWS) | Address of the row to refresh |
| burst_active | output | 1 | A burst has started and its last row is not yet accepted |

## Verification
On every cycle, the embedded assertions check the handshake rules: valid and row are held while stalled, the row advances by exactly one or wraps on acceptance, and the owed count never exceeds 8. They also check that `burst_active` only rises on an accepted row and that an expired spread interval always leaves a request pending. Only the bench scenarios can show the absolute timing: the first request landing exactly INTERVAL or WINDOW cycles after reset or after a mode change, the 20-cycle spacing under constant ready, and exactly 8 handshakes after a long stall. The bench also shows a stalled burst keeping its request up until all rows are accepted, and a mid-run reset discarding owed work.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic {
    MODE_SPREAD = 1'b0,
    MODE_BURST  = 1'b1
  } refresh_mode_e;

  // Ceiling on refreshes that may be owed in spread mode
  localparam int unsigned OWED_MAX = 8;
  localparam int unsigned OWED_W   = $clog2(OWED_MAX + 1);

  function automatic int unsigned spread_cycles(input int unsigned ret_ns,
                                                input int unsigned rows,
                                                input int unsigned clk_ns);
    return ret_ns / rows / clk_ns;
  endfunction

  function automatic int unsigned window_cycles(input int unsigned ret_ns,
                                                input int unsigned clk_ns);
    return ret_ns / clk_ns;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer
  import refresh_pkg::*;
#(
  parameter int unsigned INTERVAL = 781,
  parameter int unsigned WINDOW   = 3200000
) (
  input  logic          clk,
  input  logic          rst,
  input  refresh_mode_e mode,
  input  logic          restart,
  output logic          tick
);
  localparam int unsigned CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] SPREAD_LAST = CNT_W'(INTERVAL - 1);
  localparam logic [CNT_W-1:0] BURST_LAST  = CNT_W'(WINDOW - 1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] last;

  assign last = (mode == MODE_BURST) ? BURST_LAST : SPREAD_LAST;
  assign tick = !restart && (count_q >= last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count_q <= '0;
    end else if (count_q >= last) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

  // R9: no period expires on the edge that restarts the timer
  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (count_q == '0));

endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int unsigned ROWS = 4096
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    advance,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int unsigned ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_next;

  generate
    if ((1 << ROW_W) == ROWS) begin : g_pow2_wrap
      // Row count fills the field: natural overflow wraps to zero
      assign row_next = row_q + 1'b1;
    end else begin : g_cmp_wrap
      assign row_next = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
    end else if (advance) begin
      row_q <= row_next;
    end
  end

  assign row = row_q;

endmodule

// File: rtl/refresh_owed.sv
module refresh_owed
  import refresh_pkg::*;
#(
  parameter int unsigned ROWS = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  refresh_mode_e mode,
  input  logic          tick,
  input  logic          accept,
  output logic          pending,
  output logic          burst_active
);
  localparam int unsigned LEFT_W = $clog2(ROWS + 1);
  localparam logic [LEFT_W-1:0] FULL_BURST = LEFT_W'(ROWS);
  localparam logic [OWED_W-1:0] OWED_CAP   = OWED_W'(OWED_MAX);

  logic [LEFT_W-1:0] left_q;
  logic [OWED_W-1:0] owed_q;
  logic              active_q;
  logic              serve_burst;
  logic              serve_owed;
  logic              spread_tick;
  logic              burst_tick;

  assign spread_tick = tick && (mode == MODE_SPREAD);
  assign burst_tick  = tick && (mode == MODE_BURST);
  // A burst in progress is served before owed spread refreshes
  assign serve_burst = accept && (left_q != '0);
  assign serve_owed  = accept && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (burst_tick) begin
      left_q <= FULL_BURST;
    end else if (serve_burst) begin
      left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
    end else if (spread_tick && !serve_owed) begin
      if (owed_q != OWED_CAP) begin
        owed_q <= owed_q + 1'b1;
      end
    end else if (serve_owed && !spread_tick) begin
      owed_q <= owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
    end else if (serve_burst) begin
      active_q <= (left_q != LEFT_W'(1));
    end
  end

  assign pending      = (left_q != '0) || (owed_q != '0);
  assign burst_active = active_q;

  assert_owed_cap_R6: assert property (@(posedge clk) disable iff (rst)
    owed_q <= OWED_CAP);

  assert_owed_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (spread_tick && !accept && owed_q == OWED_CAP) |=> (owed_q == OWED_CAP));

  assert_active_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_active) |-> $past(accept));

  assert_burst_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (left_q > LEFT_W'(1)) |=> pending);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refresh_pkg::*;
#(
  parameter int unsigned RETENTION_NS  = 64000000,
  parameter int unsigned ROWS          = 4096,
  parameter int unsigned CLK_PERIOD_NS = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_burst,
  output logic                    refresh_valid,
  input  logic                    refresh_ready,
  output logic [$clog2(ROWS)-1:0] refresh_row,
  output logic                    burst_active
);
  localparam int unsigned INTERVAL = spread_cycles(RETENTION_NS, ROWS, CLK_PERIOD_NS);
  localparam int unsigned WINDOW   = window_cycles(RETENTION_NS, CLK_PERIOD_NS);
  localparam int unsigned ROW_W    = $clog2(ROWS);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  refresh_mode_e mode_in;
  refresh_mode_e mode_q;
  logic          restart;
  logic          tick;
  logic          accept;

  assign mode_in = refresh_mode_e'(mode_burst);
  assign restart = (mode_in != mode_q);
  assign accept  = refresh_valid && refresh_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_in;
    end else begin
      mode_q <= mode_in;
    end
  end

  refresh_timer #(
    .INTERVAL (INTERVAL),
    .WINDOW   (WINDOW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .restart (restart),
    .tick    (tick)
  );

  refresh_owed #(
    .ROWS (ROWS)
  ) u_owed (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode_q),
    .tick         (tick),
    .accept       (accept),
    .pending      (refresh_valid),
    .burst_active (burst_active)
  );

  refresh_row_counter #(
    .ROWS (ROWS)
  ) u_rows (
    .clk     (clk),
    .rst     (rst),
    .advance (accept),
    .row     (refresh_row)
  );

  assert_hold_req_R3: assert property (@(posedge clk) disable iff (rst)
    (refresh_valid && !refresh_ready) |=> (refresh_valid && $stable(refresh_row)));

  assert_row_step_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && refresh_row != LAST_ROW) |=> (refresh_row == $past(refresh_row) + 1'b1));

  assert_row_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(refresh_row));

  assert_row_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && refresh_row == LAST_ROW) |=> (refresh_row == '0));

  assert_spread_req_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_q == MODE_SPREAD) |=> refresh_valid);

endmodule

// File: tb/refresh_scheduler_bench.sv
module refresh_scheduler_bench;
  localparam int unsigned RET_NS = 3200;
  localparam int unsigned NROWS  = 8;
  localparam int unsigned CLK_NS = 20;
  localparam int unsigned INT_C  = RET_NS / NROWS / CLK_NS;  // 20
  localparam int unsigned WIN_C  = RET_NS / CLK_NS;          // 160
  localparam int unsigned RW     = $clog2(NROWS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_burst = 1'b0;
  logic          refresh_ready = 1'b0;
  logic          refresh_valid;
  logic [RW-1:0] refresh_row;
  logic          burst_active;

  int checks = 0;
  int fails  = 0;
  int hs_count = 0;
  int exp_row = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  refresh_scheduler #(
    .RETENTION_NS  (RET_NS),
    .ROWS          (NROWS),
    .CLK_PERIOD_NS (CLK_NS)
  ) u_refresh_scheduler (
    .clk           (clk),
    .rst           (rst),
    .mode_burst    (mode_burst),
    .refresh_valid (refresh_valid),
    .refresh_ready (refresh_ready),
    .refresh_row   (refresh_row),
    .burst_active  (burst_active)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input longint actual, input longint expected);
    check(actual == expected, req, what, actual, expected);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side of the scoreboard: queue the rows expected to be accepted
  task automatic expect_rows(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_row);
      exp_row = (exp_row + 1) % NROWS;
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1;
    refresh_ready = 1'b0;
    mode_burst = m;
    step(3);
    chk_eq("R4", "scoreboard left over before reset", exp_q.size(), 0);
    exp_q.delete();
    exp_row = 0;
    rst = 1'b0;
  endtask

  // Monitor: sample just before each rising edge and pop on acceptance
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (!rst && refresh_valid && refresh_ready) begin
        hs_count++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected handshake row", refresh_row, -1);
        end else begin
          chk_eq("R4", "accepted row", refresh_row, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    // Reset and first spread request
    do_reset(1'b0);
    chk_eq("R1", "valid after reset", refresh_valid, 0);
    chk_eq("R1", "row after reset", refresh_row, 0);
    chk_eq("R1", "burst_active after reset", burst_active, 0);
    step(INT_C - 1);
    chk_eq("R2", "valid one cycle before interval", refresh_valid, 0);
    step(1);
    chk_eq("R2", "valid at interval", refresh_valid, 1);

    // Stall: request held, row held, owed count saturates
    step(10);
    chk_eq("R3", "valid held while stalled", refresh_valid, 1);
    chk_eq("R3", "row held while stalled", refresh_row, 0);
    step(170);                       // edge 200, ten intervals expired
    refresh_ready = 1'b1;
    base = hs_count;
    expect_rows(8);
    step(12);
    chk_eq("R6", "handshakes after long stall", hs_count - base, 8);
    chk_eq("R6", "valid after owed drained", refresh_valid, 0);
    chk_eq("R5", "row wrapped to zero", refresh_row, 0);

    // Constant ready: one request per interval
    expect_rows(2);
    step(8);
    chk_eq("R2", "valid at edge 220", refresh_valid, 1);
    step(1);
    chk_eq("R2", "valid after acceptance 221", refresh_valid, 0);
    step(INT_C - 1);
    chk_eq("R2", "valid at edge 240", refresh_valid, 1);
    step(1);
    chk_eq("R2", "valid after acceptance 241", refresh_valid, 0);
    chk_eq("R4", "row after two acceptances", refresh_row, 2);

    // Mode change to burst restarts the timer
    mode_burst = 1'b1;
    expect_rows(8);
    base = hs_count;
    step(WIN_C);
    chk_eq("R9", "valid one cycle before new window", refresh_valid, 0);
    step(1);
    chk_eq("R9", "valid at new window", refresh_valid, 1);
    step(1);
    chk_eq("R8", "burst_active after first row", burst_active, 1);
    step(NROWS - 1);
    chk_eq("R8", "burst_active after last row", burst_active, 0);
    chk_eq("R7", "valid after burst", refresh_valid, 0);
    chk_eq("R7", "rows in burst", hs_count - base, NROWS);
    chk_eq("R5", "row after full burst", refresh_row, 2);

    // Burst from reset with stalls between pairs
    do_reset(1'b1);
    step(WIN_C - 1);
    chk_eq("R7", "valid one cycle before window", refresh_valid, 0);
    step(1);
    chk_eq("R7", "valid at window", refresh_valid, 1);
    expect_rows(8);
    base = hs_count;
    for (int i = 0; i < 4; i++) begin
      refresh_ready = 1'b1;
      step(2);
      refresh_ready = 1'b0;
      chk_eq("R7", "valid during stalled burst", refresh_valid, (i < 3) ? 1 : 0);
      chk_eq("R8", "burst_active during stalled burst", burst_active, (i < 3) ? 1 : 0);
      step(3);
      chk_eq("R3", "row held during burst stall", refresh_row, (2 * (i + 1)) % NROWS);
    end
    chk_eq("R7", "rows in stalled burst", hs_count - base, NROWS);

    // Reset in the middle of owed work
    do_reset(1'b0);
    refresh_ready = 1'b1;
    expect_rows(2);
    step(2 * INT_C + 1);
    refresh_ready = 1'b0;
    step(2 * INT_C);
    chk_eq("R6", "owed request pending", refresh_valid, 1);
    chk_eq("R4", "row before reset", refresh_row, 2);
    do_reset(1'b0);
    chk_eq("R1", "valid cleared by reset", refresh_valid, 0);
    chk_eq("R1", "row cleared by reset", refresh_row, 0);
    step(INT_C - 1);
    chk_eq("R1", "timer restarted by reset", refresh_valid, 0);
    step(1);
    chk_eq("R1", "first request after reset", refresh_valid, 1);
    refresh_ready = 1'b1;
    expect_rows(1);
    step(2);
    chk_eq("R4", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule